// File: doc/BRIEF.md
# Receive Packet Header Strip and Spill Stage

This block sits in a receive path between a link receiver and the buffer that feeds receive DMA. Both sides are valid/ready streams of beats. A beat is either a data byte or an end-of-packet marker. A marker beat carries a flag that tells a normal end from an error end. At the start of each packet the stage decides whether the packet goes to the channel or is thrown away. It then removes the configured leading header bytes, and enforces a maximum payload length.

A packet is taken only when the descriptor-active input is high as its first beat arrives. When no descriptor is active, a mode input selects the behaviour. One setting drains and discards the whole packet at full rate. The other holds the input off until a descriptor appears. The stage reports a cut packet and an error-terminated packet as one-cycle event pulses. It also shows a receive-active level while a taken packet is in progress. Configuration inputs are expected to be held stable for the length of a packet.

Top module: `rx_strip_spill`

## Requirements
- R1: After reset, out_valid, rx_active, trunc_pulse and eep_pulse are all 0.
- R2: With strip_addr=1 and strip_pid=0, the first data beat of each taken packet is removed, and the following bytes pass in order.
- R3: With strip_pid=1, the first two data beats of each taken packet are removed, whatever the value of strip_addr.
- R4: With both strip inputs at 0, every data byte of a taken packet passes unchanged and in order, followed by its end marker (in_eop=1 beat, out_eop=1 beat).
- R5: When desc_active=0 and no_spill=0 as a packet starts, every beat of that packet is accepted in the cycle it is offered. Nothing appears at the output, and neither event pulse fires.
- R6: When desc_active=0 and no_spill=1 as a packet starts, in_ready stays 0 until desc_active rises. After that the packet is taken normally.
- R7: When a kept byte would exceed max_len kept bytes, that byte is replaced at the output by an end marker with out_err=0. All remaining input beats up to and including the input end marker are consumed without output. trunc_pulse is 1 for exactly the cycle after that cut marker is transferred.
- R8: Stripped bytes do not count toward max_len. A packet whose kept bytes equal max_len passes whole, without a cut.
- R9: An input end marker with in_err=1 on a taken, uncut packet is forwarded with out_err=1. eep_pulse is 1 for exactly the cycle after that transfer.
- R10: A taken packet with no bytes left after stripping comes out as a single end-marker beat, which keeps its error flag.
- R11: rx_active is 1 from the cycle after the first data beat of a taken packet is accepted until the cycle after its input end marker is accepted. At all other times it is 0.
- R12: While a forwarded beat is waiting with out_ready=0, in_ready is 0 and the beat is held at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strip_addr | input | 1 | Remove first data byte of each packet |
| strip_pid | input | 1 | Remove first two data bytes of each packet |
| no_spill | input | 1 | 1: stall when no descriptor is active; 0: discard |
| desc_active | input | 1 | A receive descriptor is ready |
| max_len | input | LEN_W | Maximum kept bytes per packet |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_data | input | DATA_W | Input data byte |
| in_eop | input | 1 | Input beat is an end marker |
| in_err | input | 1 | End marker is an error end |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts beat |
| out_data | output | DATA_W | Output data byte (0 on markers) |
| out_eop | output | 1 | Output beat is an end marker |
| out_err | output | 1 | Output marker is an error end |
| rx_active | output | 1 | A taken packet is in progress |
| trunc_pulse | output | 1 | One-cycle pulse after a cut marker is sent |
| eep_pulse | output | 1 | One-cycle pulse after an error marker is forwarded |

## Verification
A header index that is off by one moves the packet by a byte. The wrong bytes then show up on out_data at the very next forwarded beat. A length count that is off puts the cut marker one beat early or late, and trunc_pulse moves with it. A start-of-packet decision that is wrong shows in the same cycle the first beat is offered: in_ready is held low when it should be high, or beats leak out during a discard. A packet state that stays stuck is visible on rx_active one cycle after the end marker, and it corrupts the handling of the next packet's header.

// File: rtl/rx_strip_pkg.sv
package rx_strip_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_PASS    = 2'd1,
      ST_DISCARD = 2'd2,
      ST_CUT     = 2'd3
   } rx_state_e;
endpackage

// File: rtl/rx_hdr_strip.sv
module rx_hdr_strip #(
   parameter int STRIP_EN = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic beat_take,
   input  logic pkt_done,
   input  logic strip_addr,
   input  logic strip_pid,
   output logic drop
);
   localparam int IDX_W = 2;

   generate
      if (STRIP_EN != 0) begin : g_strip
         logic [IDX_W-1:0] idx_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               idx_q <= '0;
            else if (pkt_done)
               idx_q <= '0;
            else if (beat_take && idx_q != '1)
               idx_q <= idx_q + 1'b1;
         end
         always_comb begin
            drop = 1'b0;
            if (idx_q == 2'd0 && (strip_addr || strip_pid)) drop = 1'b1;
            if (idx_q == 2'd1 && strip_pid)                 drop = 1'b1;
         end
      end else begin : g_nostrip
         logic unused_ok;
         assign unused_ok = &{clk, rst_n, beat_take, pkt_done, strip_addr, strip_pid};
         assign drop = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/rx_len_limit.sv
module rx_len_limit #(
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             keep_take,
   input  logic             clr,
   input  logic [LEN_W-1:0] max_len,
   output logic             at_limit
);
   logic [LEN_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (keep_take)
         cnt_q <= cnt_q + 1'b1;
   end

   assign at_limit = (cnt_q == max_len);
endmodule

// File: rtl/rx_pkt_gate.sv
module rx_pkt_gate
   import rx_strip_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      desc_active,
   input  logic      no_spill,
   input  logic      in_fire,
   input  logic      in_eop,
   input  logic      cut_now,
   output rx_state_e st,
   output logic      accepting,
   output logic      discarding,
   output logic      cutting,
   output logic      stalled
);
   rx_state_e st_q, st_d;

   assign accepting  = (st_q == ST_PASS) || (st_q == ST_IDLE && desc_active);
   assign discarding = (st_q == ST_DISCARD) ||
                       (st_q == ST_IDLE && !desc_active && !no_spill);
   assign cutting    = (st_q == ST_CUT);
   assign stalled    = (st_q == ST_IDLE) && !desc_active && no_spill;
   assign st         = st_q;

   always_comb begin
      st_d = st_q;
      if (in_fire) begin
         if (in_eop)
            st_d = ST_IDLE;
         else if (accepting)
            st_d = cut_now ? ST_CUT : ST_PASS;
         else if (discarding)
            st_d = ST_DISCARD;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end
endmodule

// File: rtl/rx_strip_spill.sv
module rx_strip_spill
   import rx_strip_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int LEN_W    = 16,
   parameter int STRIP_EN = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strip_addr,
   input  logic              strip_pid,
   input  logic              no_spill,
   input  logic              desc_active,
   input  logic [LEN_W-1:0]  max_len,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_eop,
   input  logic              in_err,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_eop,
   output logic              out_err,
   output logic              rx_active,
   output logic              trunc_pulse,
   output logic              eep_pulse
);
   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be at least 1");
      end
      if (LEN_W < 1 || LEN_W > 32) begin : g_bad_len
         $error("LEN_W must be 1..32");
      end
   endgenerate

   rx_state_e st;
   logic accepting, discarding, cutting, stalled;
   logic drop, at_limit, cut_now, fwd, in_fire;
   logic trunc_q, eep_q;

   assign cut_now  = accepting && in_valid && !in_eop && !drop && at_limit;
   assign fwd      = accepting && in_valid && (in_eop || !drop);
   assign in_ready = stalled ? 1'b0 :
                     (discarding || cutting) ? 1'b1 :
                     (accepting && fwd) ? out_ready : accepting;
   assign in_fire  = in_valid && in_ready;

   assign out_valid = fwd;
   assign out_data  = (in_eop || cut_now) ? '0 : in_data;
   assign out_eop   = in_eop || cut_now;
   assign out_err   = in_eop && in_err;

   rx_pkt_gate u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .desc_active(desc_active),
      .no_spill   (no_spill),
      .in_fire    (in_fire),
      .in_eop     (in_eop),
      .cut_now    (cut_now),
      .st         (st),
      .accepting  (accepting),
      .discarding (discarding),
      .cutting    (cutting),
      .stalled    (stalled)
   );

   rx_hdr_strip #(.STRIP_EN(STRIP_EN)) u_strip (
      .clk       (clk),
      .rst_n     (rst_n),
      .beat_take (in_fire && accepting && !in_eop),
      .pkt_done  (in_fire && in_eop),
      .strip_addr(strip_addr),
      .strip_pid (strip_pid),
      .drop      (drop)
   );

   rx_len_limit #(.LEN_W(LEN_W)) u_len (
      .clk      (clk),
      .rst_n    (rst_n),
      .keep_take(in_fire && accepting && !in_eop && !drop && !cut_now),
      .clr      (in_fire && in_eop),
      .max_len  (max_len),
      .at_limit (at_limit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trunc_q <= 1'b0;
         eep_q   <= 1'b0;
      end else begin
         trunc_q <= in_fire && cut_now;
         eep_q   <= in_fire && accepting && in_eop && in_err;
      end
   end

   assign trunc_pulse = trunc_q;
   assign eep_pulse   = eep_q;
   assign rx_active   = (st == ST_PASS) || (st == ST_CUT);
endmodule

// File: rtl/rx_strip_spill_chk.sv
module rx_strip_spill_chk
   import rx_strip_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      no_spill,
   input logic      desc_active,
   input logic      in_valid,
   input logic      in_ready,
   input logic      in_eop,
   input logic      out_valid,
   input logic      out_ready,
   input logic      out_eop,
   input logic      out_err,
   input logic      rx_active,
   input logic      trunc_pulse,
   input logic      eep_pulse,
   input rx_state_e st
);
   p_discard_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DISCARD) |-> (!out_valid && in_ready));

   p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && no_spill && !desc_active) |-> !in_ready);

   p_trunc_after_cut_r7: assert property (@(posedge clk) disable iff (!rst_n)
      trunc_pulse |-> $past(out_valid && out_ready && out_eop && !out_err));

   p_eep_after_marker_r9: assert property (@(posedge clk) disable iff (!rst_n)
      eep_pulse |-> $past(out_valid && out_ready && out_eop && out_err));

   p_active_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_active) |-> $past(in_valid && in_ready && in_eop));

   p_backpressure_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   p_pulse_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(trunc_pulse && eep_pulse));
endmodule

bind rx_strip_spill rx_strip_spill_chk i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .no_spill   (no_spill),
   .desc_active(desc_active),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .in_eop     (in_eop),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_eop    (out_eop),
   .out_err    (out_err),
   .rx_active  (rx_active),
   .trunc_pulse(trunc_pulse),
   .eep_pulse  (eep_pulse),
   .st         (st)
);

// File: tb/test_rx_strip_spill.sv
`timescale 1ns/1ps
module test_rx_strip_spill;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strip_addr = 1'b0, strip_pid = 1'b0, no_spill = 1'b0;
   logic        desc_active = 1'b1;
   logic [15:0] max_len = 16'd16;
   logic        in_valid = 1'b0, in_eop = 1'b0, in_err = 1'b0;
   logic [7:0]  in_data = 8'd0;
   logic        in_ready, out_valid, out_eop, out_err, rx_active, trunc_pulse, eep_pulse;
   logic        out_ready = 1'b1;
   logic [7:0]  out_data;

   int checks = 0, errors = 0;
   int stall_cycles = 0;
   int n_trunc = 0, n_eep = 0;
   logic bp_en = 1'b0, hold_lo = 1'b0;
   logic [7:0] cap_d[$];
   logic       cap_e[$];
   logic       cap_r[$];

   always #2.5 clk = ~clk;

   rx_strip_spill i_rx_strip_spill (
      .clk(clk), .rst_n(rst_n), .strip_addr(strip_addr), .strip_pid(strip_pid),
      .no_spill(no_spill), .desc_active(desc_active), .max_len(max_len),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .in_eop(in_eop), .in_err(in_err), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_eop(out_eop), .out_err(out_err),
      .rx_active(rx_active), .trunc_pulse(trunc_pulse), .eep_pulse(eep_pulse)
   );

   always @(posedge clk) begin
      #1;
      out_ready = hold_lo ? 1'b0 : (bp_en ? ~out_ready : 1'b1);
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid && out_ready) begin
            cap_d.push_back(out_data);
            cap_e.push_back(out_eop);
            cap_r.push_back(out_err);
         end
         if (trunc_pulse) n_trunc++;
         if (eep_pulse) n_eep++;
      end
   end

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic beat(input logic [7:0] d, input logic e, input logic r);
      in_valid = 1'b1; in_data = d; in_eop = e; in_err = r;
      @(negedge clk);
      while (!in_ready) begin
         stall_cycles++;
         @(negedge clk);
      end
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   task automatic send_pkt(input int n, input logic [7:0] base, input logic err);
      for (int i = 0; i < n; i++) beat(base + 8'(i), 1'b0, 1'b0);
      beat(8'd0, 1'b1, err);
   endtask

   task automatic clear_cap();
      cap_d.delete(); cap_e.delete(); cap_r.delete();
      n_trunc = 0; n_eep = 0; stall_cycles = 0;
   endtask

   // Vector fields: {strip_addr, strip_pid, data bytes[7:0], max_len[7:0], err}
   localparam int NV = 10;
   localparam logic [18:0] VEC [NV] = '{
      {1'b0, 1'b0, 8'd4, 8'd16, 1'b0},  // R4 plain
      {1'b1, 1'b0, 8'd4, 8'd16, 1'b0},  // R2 address strip
      {1'b0, 1'b1, 8'd4, 8'd16, 1'b0},  // R3 pid forces address strip
      {1'b1, 1'b1, 8'd5, 8'd16, 1'b1},  // R3 both set, R9 EEP
      {1'b0, 1'b0, 8'd6, 8'd3,  1'b0},  // R7 cut
      {1'b0, 1'b1, 8'd6, 8'd3,  1'b1},  // R7 cut hides EEP
      {1'b1, 1'b0, 8'd1, 8'd16, 1'b0},  // R10 empty
      {1'b0, 1'b1, 8'd1, 8'd16, 1'b1},  // R10 empty with EEP
      {1'b0, 1'b1, 8'd5, 8'd3,  1'b0},  // R8 stripped not counted
      {1'b0, 1'b0, 8'd0, 8'd0,  1'b0}   // R10 marker only
   };

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #1;
      // R1 reset values while reset is asserted and just after release
      chk(!out_valid && !rx_active && !trunc_pulse && !eep_pulse, "R1 reset outputs",
          {out_valid, rx_active, trunc_pulse, eep_pulse}, 0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk(!out_valid && !rx_active, "R1 after release", {out_valid, rx_active}, 0);

      for (int v = 0; v < NV; v++) begin
         automatic logic sa = VEC[v][18];
         automatic logic sp = VEC[v][17];
         automatic int   n  = int'(VEC[v][16:9]);
         automatic int   ml = int'(VEC[v][8:1]);
         automatic logic er = VEC[v][0];
         automatic logic [7:0] base = 8'(8'h20 + 16 * v);
         automatic int skip = sp ? 2 : (sa ? 1 : 0);
         automatic int kept = (n > skip) ? n - skip : 0;
         automatic logic cut = kept > ml;
         automatic int nout = cut ? ml : kept;
         automatic logic bad = 1'b0;
         clear_cap();
         strip_addr = sa; strip_pid = sp; max_len = 16'(ml);
         bp_en = v[0];
         send_pkt(n, base, er);
         bp_en = 1'b0;
         repeat (4) @(posedge clk); #1;
         if (cap_d.size() != nout + 1) bad = 1'b1;
         else begin
            for (int i = 0; i < nout; i++)
               if (cap_e[i] || cap_d[i] != base + 8'(skip + i)) bad = 1'b1;
            if (!cap_e[nout] || cap_r[nout] != (cut ? 1'b0 : er)) bad = 1'b1;
         end
         // R2 R3 R4 R7 R8 R10 packet contents
         chk(!bad, $sformatf("R2/R3/R4/R7/R8/R10 vector %0d beats", v),
             cap_d.size(), nout + 1);
         chk(n_trunc == (cut ? 1 : 0), $sformatf("R7 vector %0d trunc pulses", v),
             n_trunc, cut ? 1 : 0);
         chk(n_eep == ((er && !cut) ? 1 : 0), $sformatf("R9 vector %0d eep pulses", v),
             n_eep, (er && !cut) ? 1 : 0);
      end
      strip_addr = 1'b0; strip_pid = 1'b0; max_len = 16'd16;

      // R5 discard mode
      clear_cap();
      desc_active = 1'b0; no_spill = 1'b0;
      send_pkt(3, 8'h70, 1'b1);
      repeat (3) @(posedge clk); #1;
      chk(stall_cycles == 0, "R5 full rate consume", stall_cycles, 0);
      chk(cap_d.size() == 0, "R5 no output", cap_d.size(), 0);
      chk(n_eep == 0 && n_trunc == 0, "R5 no pulses", n_eep + n_trunc, 0);

      // R6 stall mode, then R11 rx_active window
      clear_cap();
      no_spill = 1'b1;
      fork
         send_pkt(3, 8'h80, 1'b0);
         begin
            repeat (5) @(negedge clk);
            chk(in_ready == 1'b0, "R6 held off", in_ready, 0);
            chk(cap_d.size() == 0, "R6 nothing passed", cap_d.size(), 0);
            @(posedge clk); #1;
            desc_active = 1'b1;
            @(posedge clk); #1;   // first beat accepted at this edge
            @(negedge clk);
            chk(rx_active == 1'b1, "R11 active after first beat", rx_active, 1);
         end
      join
      @(negedge clk);
      chk(rx_active == 1'b0, "R11 inactive after marker", rx_active, 0);
      repeat (2) @(posedge clk); #1;
      chk(cap_d.size() == 4 && cap_d[0] == 8'h80 && cap_d[2] == 8'h82 && cap_e[3],
          "R6 packet after release", cap_d.size(), 4);
      no_spill = 1'b0;

      // R12 output backpressure
      clear_cap();
      hold_lo = 1'b1;
      @(posedge clk); #1;
      fork
         send_pkt(2, 8'h90, 1'b0);
         begin
            repeat (3) @(negedge clk);
            chk(out_valid && !in_ready && out_data == 8'h90, "R12 held beat",
                {out_valid, in_ready}, 2);
            @(posedge clk); #1;
            hold_lo = 1'b0;
         end
      join
      repeat (3) @(posedge clk); #1;
      chk(cap_d.size() == 3 && cap_d[0] == 8'h90 && cap_d[1] == 8'h91, "R12 order kept",
          cap_d.size(), 3);

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule